// File: doc/BRIEF.md
# Page Access Permission Guard

This block decides, for each memory access made under translated addressing, whether the access may proceed. It takes four things about the request: the kind of access, whether the requester is privileged, the executable and writable bits of the matching page entry, and that entry's 4-bit zone index. The zone index selects a 2-bit override field from a 32-bit zone register that software loads as a whole word. The override can take rights away from user code or give rights that the page bits do not give. Zone overrides are the only means of stopping user code from reading a page.

Instruction fetches are judged only when the fetched instruction is really executed. A fetch that the pipeline discards never reaches the verdict stage and never raises a fault. Each accepted request gives a registered verdict one cycle later: a response strobe, a grant, and at most one of two fault flags. Fetch violations raise the instruction fault. Load and store violations raise the data fault.

The number of implemented zones is a parameter of at most 16. Zones at or above that count cannot be written, read back as `11`, and grant execute and write access.

Top module: `page_access_guard`

## Requirements
- R1: After reset the zone register reads zero in every implemented zone, and the response strobe, grant and both fault flags are low.
- R2: A write strobe loads the full 32-bit word into the zone register. Zone n occupies bits [2n+1:2n], so a 4-bit zone index of 0101 selects bits [11:10]. The register is read back unchanged in its implemented zones.
- R3: Access kind is coded 00 load, 01 store, 10 execute, 11 none. A request of kinds 00, 01 or an executed 10 gives `resp_valid` plus its verdict exactly one clock after `req_valid`. Kind 11 gives no response.
- R4: In zone mode 01, an execute is granted exactly when the page executable bit is 1. Otherwise `inst_fault` is raised.
- R5: An execute request whose `exec_commit` is low is a discarded fetch. It gives no response and no fault, even when the page forbids execution.
- R6: In zone mode 01, a store is granted exactly when the page writable bit is 1. Otherwise `data_fault` is raised.
- R7: In zone mode 00, every access made in user mode is denied. This includes loads. Loads and stores raise `data_fault`, and executes raise `inst_fault`.
- R8: Privileged loads are always granted. In user mode, loads are granted in every zone mode other than 00, whatever the page bits.
- R9: Zone mode 11 grants execute and store in both privilege modes, whatever the page bits.
- R10: Zone mode 10 acts as mode 01 in user mode and as mode 11 in privileged mode.
- R11: In zone mode 00, privileged accesses are judged by the page bits alone, as in mode 01.
- R12: A zone index at or above the implemented zone count acts as mode 11, and that zone reads back as 11.
- R13: A response never has both fault flags high. A response with a fault always has grant low.
- R14: A request in the same cycle as a zone register write is judged with the zone value that held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zone_wr_en | input | 1 | Loads `zone_wr_data` into the zone register |
| zone_wr_data | input | 32 | New zone register word |
| zone_rd_data | output | 32 | Current zone register contents |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 00 load, 01 store, 10 execute, 11 none |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| exec_commit | input | 1 | Fetched instruction is being executed |
| page_exec | input | 1 | Page entry executable bit |
| page_write | input | 1 | Page entry writable bit |
| page_zone | input | 4 | Page entry zone index |
| resp_valid | output | 1 | Verdict for the request of the previous cycle |
| grant | output | 1 | Access allowed |
| inst_fault | output | 1 | Instruction-storage fault |
| data_fault | output | 1 | Data-storage fault |

## Verification
A zone register write and an access request can fall in the same clock. The bench provokes this by writing a word that opens zone 0 in the same cycle as a user load to zone 0, while zone 0 is still in the locked mode 00. The verdict is judged against the old value, so a data fault is expected. An identical load one cycle later must then be granted. Separately, every combination of kind, privilege, page bits and zone index is swept against a rule model. The sweep runs on a full 16-zone instance and on a 4-zone instance.

// File: rtl/pag_pkg.sv
package pag_pkg;

    localparam int ZONE_W    = 2;
    localparam int MAX_ZONES = 16;
    localparam int ZREG_W    = ZONE_W * MAX_ZONES;
    localparam int ZSEL_W    = $clog2(MAX_ZONES);

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        ZM_LOCK  = 2'b00,
        ZM_PAGE  = 2'b01,
        ZM_SPLIT = 2'b10,
        ZM_OPEN  = 2'b11
    } zone_mode_e;

    typedef struct packed {
        logic valid;
        logic grant;
        logic ifault;
        logic dfault;
    } verdict_t;

endpackage

// File: rtl/pag_zone_reg.sv
module pag_zone_reg
    import pag_pkg::*;
#(
    parameter int NUM_ZONES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ZREG_W-1:0] wr_data,
    output logic [ZREG_W-1:0] rd_data,
    input  logic [ZSEL_W-1:0] sel,
    output zone_mode_e        sel_mode
);

    localparam int IMPL_W = NUM_ZONES * ZONE_W;

    logic [IMPL_W-1:0] fields_d, fields_q;
    logic [ZONE_W-1:0] view [MAX_ZONES];
    logic              armed_q;

    always_comb begin
        fields_d = fields_q;
        if (wr_en) begin
            fields_d = wr_data[IMPL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
            armed_q  <= 1'b0;
        end else begin
            fields_q <= fields_d;
            armed_q  <= 1'b1;
        end
    end

    for (genvar g = 0; g < MAX_ZONES; g++) begin : g_zone
        if (g < NUM_ZONES) begin : g_impl
            assign view[g] = fields_q[g*ZONE_W +: ZONE_W];
        end else begin : g_absent
            assign view[g] = 2'b11;
        end
        assign rd_data[g*ZONE_W +: ZONE_W] = view[g];
    end

    assign sel_mode = zone_mode_e'(view[sel]);

    assert_zone_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(wr_en)) |-> (rd_data[IMPL_W-1:0] == $past(wr_data[IMPL_W-1:0])))
        else $error("zone register did not take the written word");

    if (NUM_ZONES < MAX_ZONES) begin : g_absent_chk
        assert_absent_open_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (sel >= ZSEL_W'(NUM_ZONES)) |-> (sel_mode == ZM_OPEN))
            else $error("unimplemented zone not treated as open");
    end

endmodule

// File: rtl/pag_rule.sv
module pag_rule
    import pag_pkg::*;
(
    input  acc_kind_e  kind,
    input  logic       priv,
    input  logic       pg_exec,
    input  logic       pg_write,
    input  zone_mode_e mode,
    output logic       allow,
    output logic       ifault,
    output logic       dfault
);

    logic user_locked;
    logic full_rights;
    logic may_load, may_exec, may_store;

    always_comb begin
        user_locked = (mode == ZM_LOCK) && !priv;
        full_rights = (mode == ZM_OPEN) || ((mode == ZM_SPLIT) && priv);
        may_load    = !user_locked;
        may_exec    = !user_locked && (full_rights || pg_exec);
        may_store   = !user_locked && (full_rights || pg_write);

        allow  = 1'b0;
        ifault = 1'b0;
        dfault = 1'b0;
        unique case (kind)
            ACC_LOAD: begin
                allow  = may_load;
                dfault = !may_load;
            end
            ACC_STORE: begin
                allow  = may_store;
                dfault = !may_store;
            end
            ACC_EXEC: begin
                allow  = may_exec;
                ifault = !may_exec;
            end
            default: begin
                allow = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (kind == ACC_LOAD && priv) begin
            assert_priv_load_open_R8: assert (allow && !dfault)
                else $error("privileged load refused");
        end
    end

endmodule

// File: rtl/page_access_guard.sv
module page_access_guard
    import pag_pkg::*;
#(
    parameter int NUM_ZONES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        zone_wr_en,
    input  logic [31:0] zone_wr_data,
    output logic [31:0] zone_rd_data,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic        req_priv,
    input  logic        exec_commit,
    input  logic        page_exec,
    input  logic        page_write,
    input  logic [3:0]  page_zone,
    output logic        resp_valid,
    output logic        grant,
    output logic        inst_fault,
    output logic        data_fault
);

    acc_kind_e  kind;
    zone_mode_e cur_mode;
    logic       rule_allow, rule_if, rule_df;
    logic       accept;
    verdict_t   verdict_d, verdict_q;
    logic       armed_q;

    assign kind = acc_kind_e'(req_kind);

    pag_zone_reg #(.NUM_ZONES(NUM_ZONES)) u_zones (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (zone_wr_en),
        .wr_data  (zone_wr_data),
        .rd_data  (zone_rd_data),
        .sel      (page_zone),
        .sel_mode (cur_mode)
    );

    pag_rule u_rule (
        .kind     (kind),
        .priv     (req_priv),
        .pg_exec  (page_exec),
        .pg_write (page_write),
        .mode     (cur_mode),
        .allow    (rule_allow),
        .ifault   (rule_if),
        .dfault   (rule_df)
    );

    always_comb begin
        accept = req_valid && (kind != ACC_NONE) && ((kind != ACC_EXEC) || exec_commit);
        verdict_d.valid  = accept;
        verdict_d.grant  = accept && rule_allow;
        verdict_d.ifault = accept && rule_if;
        verdict_d.dfault = accept && rule_df;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '0;
            armed_q   <= 1'b0;
        end else begin
            verdict_q <= verdict_d;
            armed_q   <= 1'b1;
        end
    end

    assign resp_valid = verdict_q.valid;
    assign grant      = verdict_q.grant;
    assign inst_fault = verdict_q.ifault;
    assign data_fault = verdict_q.dfault;

    assert_resp_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && resp_valid) |-> $past(req_valid))
        else $error("response without request");

    assert_discarded_fetch_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(req_valid && kind == ACC_EXEC && !exec_commit)) |-> (!inst_fault && !resp_valid))
        else $error("discarded fetch produced a verdict");

    assert_single_fault_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_fault || data_fault) |-> (resp_valid && !grant && !(inst_fault && data_fault)))
        else $error("fault flags inconsistent");

    assert_user_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(req_valid && !req_priv && kind == ACC_LOAD && cur_mode == ZM_LOCK)) |-> data_fault)
        else $error("locked zone let a user load through");

    assert_priv_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(req_valid && req_priv && kind == ACC_LOAD)) |-> grant)
        else $error("privileged load not granted");

endmodule

// File: tb/tb_page_access_guard.sv
module tb_page_access_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        zone_wr_en = 1'b0;
    logic [31:0] zone_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_priv = 1'b0;
    logic        exec_commit = 1'b0;
    logic        page_exec = 1'b0;
    logic        page_write = 1'b0;
    logic [3:0]  page_zone = '0;

    logic [31:0] rd_w, rd_n;
    logic        rv_w, gr_w, if_w, df_w;
    logic        rv_n, gr_n, if_n, df_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    page_access_guard #(.NUM_ZONES(16)) dut (
        .clk(clk), .rst_n(rst_n), .zone_wr_en(zone_wr_en), .zone_wr_data(zone_wr_data),
        .zone_rd_data(rd_w), .req_valid(req_valid), .req_kind(req_kind), .req_priv(req_priv),
        .exec_commit(exec_commit), .page_exec(page_exec), .page_write(page_write),
        .page_zone(page_zone), .resp_valid(rv_w), .grant(gr_w), .inst_fault(if_w), .data_fault(df_w)
    );

    page_access_guard #(.NUM_ZONES(4)) dut_narrow (
        .clk(clk), .rst_n(rst_n), .zone_wr_en(zone_wr_en), .zone_wr_data(zone_wr_data),
        .zone_rd_data(rd_n), .req_valid(req_valid), .req_kind(req_kind), .req_priv(req_priv),
        .exec_commit(exec_commit), .page_exec(page_exec), .page_write(page_write),
        .page_zone(page_zone), .resp_valid(rv_n), .grant(gr_n), .inst_fault(if_n), .data_fault(df_n)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // expected {valid, grant, ifault, dfault}
    function automatic logic [3:0] model(input int kind, input bit priv, input bit ex, input bit wr,
                                         input int zv, input bit commit);
        bit locked = (zv == 0) && !priv;
        bit full   = (zv == 3) || (zv == 2 && priv);
        if (kind == 3 || (kind == 2 && !commit)) return 4'b0000;
        if (kind == 0) return locked ? 4'b1001 : 4'b1100;
        if (kind == 1) return (!locked && (full || wr)) ? 4'b1100 : 4'b1001;
        return (!locked && (full || ex)) ? 4'b1100 : 4'b1010;
    endfunction

    function automatic string tag_of(input int kind, input bit priv, input int zv);
        if (zv == 0 && !priv) return "R7";
        if (zv == 0) return "R11";
        if (kind == 0) return "R8";
        if (zv == 3) return "R9";
        if (zv == 2) return "R10";
        if (kind == 2) return "R4";
        return "R6";
    endfunction

    task automatic write_zones(input logic [31:0] w);
        @(negedge clk);
        zone_wr_en = 1'b1;
        zone_wr_data = w;
        @(negedge clk);
        zone_wr_en = 1'b0;
    endtask

    task automatic issue(input int kind, input bit priv, input bit ex, input bit wr,
                         input int zone, input bit commit);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind = kind[1:0];
        req_priv = priv;
        page_exec = ex;
        page_write = wr;
        page_zone = zone[3:0];
        exec_commit = commit;
        @(negedge clk);
        req_valid = 1'b0;
        exec_commit = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "zone readback wide", rd_w, 32'h0);
        check("R1", "zone readback narrow", rd_n, 32'hFFFF_FF00);
        check("R1", "outputs", {28'h0, rv_w, gr_w, if_w, df_w}, 32'h0);
    endtask

    task automatic t_write_and_position();
        write_zones(32'h1B2C_E4D7);
        check("R2", "readback", rd_w, 32'h1B2C_E4D7);
        check("R12", "narrow readback", rd_n, 32'hFFFF_FFD7);
        write_zones(32'h5555_5155);
        issue(0, 0, 1, 1, 5, 0);
        check("R2", "zone 5 locked user load", {28'h0, rv_w, gr_w, if_w, df_w}, 32'h9);
        issue(0, 0, 1, 1, 4, 0);
        check("R2", "zone 4 user load", {28'h0, rv_w, gr_w, if_w, df_w}, 32'hC);
    endtask

    task automatic t_sweep();
        bit both_seen = 0;
        write_zones(32'hE4E4_E4E4);
        for (int z = 0; z < 16; z++)
            for (int k = 0; k < 3; k++)
                for (int p = 0; p < 2; p++)
                    for (int e = 0; e < 2; e++)
                        for (int w = 0; w < 2; w++) begin
                            int zv = z % 4;
                            int zn = (z < 4) ? zv : 3;
                            logic [3:0] ew = model(k, p[0], e[0], w[0], zv, 1'b1);
                            logic [3:0] en = model(k, p[0], e[0], w[0], zn, 1'b1);
                            issue(k, p[0], e[0], w[0], z, 1'b1);
                            check(tag_of(k, p[0], zv), "sweep wide", {28'h0, rv_w, gr_w, if_w, df_w}, {28'h0, ew});
                            check((z < 4) ? tag_of(k, p[0], zn) : "R12", "sweep narrow",
                                  {28'h0, rv_n, gr_n, if_n, df_n}, {28'h0, en});
                            if ((if_w && df_w) || ((if_w || df_w) && gr_w)) both_seen = 1;
                        end
        check("R13", "fault exclusivity", {31'h0, both_seen}, 32'h0);
    endtask

    task automatic t_no_response();
        issue(3, 0, 0, 0, 0, 1'b1);
        check("R3", "kind none", {28'h0, rv_w, gr_w, if_w, df_w}, 32'h0);
        issue(2, 0, 0, 0, 1, 1'b0);
        check("R5", "discarded fetch", {28'h0, rv_w, gr_w, if_w, df_w}, 32'h0);
        issue(2, 0, 0, 0, 1, 1'b1);
        check("R5", "executed fetch faults", {28'h0, rv_w, gr_w, if_w, df_w}, 32'hA);
    endtask

    task automatic t_same_cycle();
        // zone 0 is 00 (locked) from the sweep word; open it while loading
        @(negedge clk);
        zone_wr_en = 1'b1;
        zone_wr_data = 32'hE4E4_E4E5;
        req_valid = 1'b1;
        req_kind = 2'b00;
        req_priv = 1'b0;
        page_zone = 4'd0;
        @(negedge clk);
        zone_wr_en = 1'b0;
        req_valid = 1'b0;
        check("R14", "old zone value judged", {28'h0, rv_w, gr_w, if_w, df_w}, 32'h9);
        issue(0, 0, 0, 0, 0, 0);
        check("R14", "new zone value next", {28'h0, rv_w, gr_w, if_w, df_w}, 32'hC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_and_position();
        t_sweep();
        t_no_response();
        t_same_cycle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule